// File: doc/BRIEF.md
# Multi-Channel DMA Register Bank

This block is the software-visible control and status front end of a sixteen-channel DMA controller. A 32-bit register port reaches two windows. The main window is 4 KiB. It holds channels 0 to 14 and two global words: a read-only interrupt summary and a channel enable word. Channel 15 has the same register layout but sits in its own 256-byte window. Each channel holds a control/status word, a control-block address, a debug word, and a read-only mirror of the control block that the engine is currently working on.

The transfer engine is not part of this block. Stub ports stand in for it. A load port fills a channel's mirror registers. A one-cycle start pulse goes out when software sets a channel's active bit. A done input tells the bank that the current control block has finished. The bank then updates status and raises that channel's interrupt line if the block asked for one.

Top module: `dma_regbank`

## Requirements
- R1: After reset the enable word reads 0x0000FFFF, the interrupt summary reads 0, and every channel's control-block address reads 0. Every channel's control/status reads 0x00000010, because only the idle bit is set.
- R2: In the main window (`bus_win`=0), for addresses below 0xF00, bits [11:8] select channel 0..14 and bits [7:0] select the register. In the second window (`bus_win`=1), only bits [7:0] are used, and they address channel 15. Register offsets are: 0x00 control/status, 0x04 control-block address, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C next block, 0x20 debug. Read data and the error flag appear in the cycle after the request.
- R3: A write to control/status changes only the bits under mask 0x30FF0001 (bit 0 active, bits 23:16, bits 29:28). All other stored bits keep their value. Bit 30 (abort) and bit 31 (reset) always read 0.
- R4: A control/status write with bit 31 set clears the whole stored word of that channel, including its interrupt, summary bit and interrupt line. No other bit of that write takes effect.
- R5: Info, source, destination, length, stride and next-block registers are loaded only through the control-block load port. Bus writes to them have no effect.
- R6: A control/status write that takes active from 0 to 1 produces a `eng_start` pulse on that channel's bit for exactly one cycle, in the cycle after the write. A write to a channel that is already active produces no pulse.
- R7: Writing 1 to control/status bit 2 clears the interrupt bit, the channel's summary bit and its `chan_irq` line. Writing 1 to bit 1 clears the end bit.
- R8: `eng_done` on an active channel clears active and sets end (bit 1). If bit 0 of the mirrored info word is 1, it also sets interrupt (bit 2), the summary bit and `chan_irq` in the next cycle. `eng_done` on an idle channel is ignored.
- R9: An access to an undecoded offset, or with `bus_be` other than 4'hF, returns data 0, pulses `bus_err` for one cycle and changes no state.
- R10: Main-window offset 0xFE0 is the interrupt summary, one bit per channel, and writes to it are ignored. Offset 0xFF0 is the enable word: only bits [15:0] are stored, they read back zero-extended, and they drive `chan_enable`.
- R11: Control/status bit 4 (idle) reads 1 whenever the channel's active bit is 0, and 0 while it is 1.
- R12: Control-block address and debug registers are fully read-write, 32 bits each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_win | input | 1 | 0 selects the main window, 1 the channel-15 window |
| bus_addr | input | 12 | Byte address within the window |
| bus_be | input | 4 | Byte enables; only 4'hF is valid |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle flag for an invalid access |
| cb_ld_valid | input | 1 | Load the control-block mirror of one channel |
| cb_ld_chan | input | 4 | Channel to load |
| cb_ld_info | input | 32 | Info word (bit 0 = interrupt on completion) |
| cb_ld_src | input | 32 | Source address |
| cb_ld_dst | input | 32 | Destination address |
| cb_ld_len | input | 32 | Transfer length |
| cb_ld_stride | input | 32 | Stride word |
| cb_ld_next | input | 32 | Next control-block address |
| eng_done | input | 16 | Per-channel completion from the engine |
| eng_start | output | 16 | Per-channel one-cycle start pulse |
| chan_enable | output | 16 | Stored enable word |
| chan_irq | output | 16 | Per-channel interrupt line |

## Verification
Status is held in two places: in each channel's control/status word and in the summary word. A fault in either shows at the ports as `chan_irq` disagreeing with a summary read, or as a control/status read that does not match the expected value. A wrong mask or a wrong clear shows up on the next read of that channel. A wrong active bit shows up as a wrong idle bit on a read. In the very next cycle it also shows as a missing, repeated or spurious `eng_start` pulse, or as `eng_done` having no effect. A decode fault shows up as data written to one channel or window being read back from another, or as `bus_err` on the cycle after the access.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

    localparam int NUM_CH = 16;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int BE_W   = DW / 8;

    // control/status bit positions (software-visible)
    localparam int CS_ACT   = 0;
    localparam int CS_END   = 1;
    localparam int CS_INT   = 2;
    localparam int CS_IDLE  = 4;
    localparam int CS_RST   = 31;
    localparam logic [DW-1:0] CS_WMASK = 32'h30FF_0001;

    localparam int INFO_IRQ_EN = 0;

    localparam logic [AW-1:0] GSTAT_OFF = 12'hFE0;
    localparam logic [AW-1:0] GEN_OFF   = 12'hFF0;

    typedef enum logic [3:0] {
        RG_CS, RG_CBA, RG_INFO, RG_SRC, RG_DST,
        RG_LEN, RG_STRIDE, RG_NEXT, RG_DBG, RG_NONE
    } reg_e;

    typedef struct packed {
        logic [DW-1:0] info;
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] len;
        logic [DW-1:0] stride;
        logic [DW-1:0] next;
    } cb_t;

    typedef struct packed {
        logic            chan_hit;
        logic [CH_W-1:0] chan;
        reg_e            rsel;
        logic            gstat_hit;
        logic            gen_hit;
        logic            bad;
    } dec_t;

    function automatic reg_e reg_of(input logic [7:0] off);
        case (off)
            8'h00:   return RG_CS;
            8'h04:   return RG_CBA;
            8'h08:   return RG_INFO;
            8'h0C:   return RG_SRC;
            8'h10:   return RG_DST;
            8'h14:   return RG_LEN;
            8'h18:   return RG_STRIDE;
            8'h1C:   return RG_NEXT;
            8'h20:   return RG_DBG;
            default: return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
    import dma_rb_pkg::*;
(
    input  logic            win,
    input  logic [AW-1:0]   addr,
    input  logic [BE_W-1:0] be,
    output dec_t            dec
);

    always_comb begin
        dec      = '0;
        dec.rsel = RG_NONE;
        if (win) begin
            dec.chan     = CH_W'(NUM_CH - 1);
            dec.rsel     = reg_of(addr[7:0]);
            dec.chan_hit = (dec.rsel != RG_NONE);
        end else if (int'(addr[AW-1:8]) < NUM_CH - 1) begin
            dec.chan     = CH_W'(addr[AW-1:8]);
            dec.rsel     = reg_of(addr[7:0]);
            dec.chan_hit = (dec.rsel != RG_NONE);
        end else begin
            dec.gstat_hit = (addr == GSTAT_OFF);
            dec.gen_hit   = (addr == GEN_OFF);
        end
        dec.bad = !(dec.chan_hit || dec.gstat_hit || dec.gen_hit) || (be != '1);
        if (dec.bad) begin
            dec.chan_hit  = 1'b0;
            dec.gstat_hit = 1'b0;
            dec.gen_hit   = 1'b0;
        end
    end

endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
    import dma_rb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_e          rsel,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    input  logic          ld,
    input  cb_t           cb_in,
    output logic [DW-1:0] cs_rd,
    output logic [DW-1:0] cba,
    output logic [DW-1:0] dbg,
    output cb_t           cb,
    output logic          start,
    output logic          irq,
    output logic          int_set,
    output logic          int_clr
);

    typedef struct packed {
        logic [DW-1:0] cs;
        logic [DW-1:0] cba;
        logic [DW-1:0] dbg;
        cb_t           cb;
        logic          start;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_en) begin
            case (rsel)
                RG_CS: begin
                    if (wdata[CS_RST]) begin
                        st_d.cs = '0;
                    end else begin
                        if (wdata[CS_END]) st_d.cs[CS_END] = 1'b0;
                        if (wdata[CS_INT]) st_d.cs[CS_INT] = 1'b0;
                        st_d.cs = (st_d.cs & ~CS_WMASK) | (wdata & CS_WMASK);
                        st_d.start = !st_q.cs[CS_ACT] && wdata[CS_ACT];
                    end
                end
                RG_CBA:  st_d.cba = wdata;
                RG_DBG:  st_d.dbg = wdata;
                default: ;
            endcase
        end
        if (ld) begin
            st_d.cb = cb_in;
        end
        if (done && st_q.cs[CS_ACT]) begin
            st_d.cs[CS_ACT] = 1'b0;
            st_d.cs[CS_END] = 1'b1;
            if (st_q.cb.info[INFO_IRQ_EN]) begin
                st_d.cs[CS_INT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_set = st_d.cs[CS_INT] & ~st_q.cs[CS_INT];
    assign int_clr = ~st_d.cs[CS_INT] & st_q.cs[CS_INT];
    assign cs_rd   = {st_q.cs[DW-1:CS_IDLE+1], ~st_q.cs[CS_ACT], st_q.cs[CS_IDLE-1:0]};
    assign cba     = st_q.cba;
    assign dbg     = st_q.dbg;
    assign cb      = st_q.cb;
    assign start   = st_q.start;
    assign irq     = st_q.cs[CS_INT];

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_win,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    input  logic              cb_ld_valid,
    input  logic [CH_W-1:0]   cb_ld_chan,
    input  logic [DW-1:0]     cb_ld_info,
    input  logic [DW-1:0]     cb_ld_src,
    input  logic [DW-1:0]     cb_ld_dst,
    input  logic [DW-1:0]     cb_ld_len,
    input  logic [DW-1:0]     cb_ld_stride,
    input  logic [DW-1:0]     cb_ld_next,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [NUM_CH-1:0] eng_start,
    output logic [NUM_CH-1:0] chan_enable,
    output logic [NUM_CH-1:0] chan_irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] gstat;
        logic [NUM_CH-1:0] gen;
        logic [DW-1:0]     rdata;
        logic              err;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;
    cb_t     cb_load;

    logic [DW-1:0]     cs_rd  [NUM_CH];
    logic [DW-1:0]     cba_rd [NUM_CH];
    logic [DW-1:0]     dbg_rd [NUM_CH];
    cb_t               cb_rd  [NUM_CH];
    logic [NUM_CH-1:0] int_set, int_clr;
    logic [DW-1:0]     chan_word;

    assign cb_load = '{info: cb_ld_info, src: cb_ld_src, dst: cb_ld_dst,
                       len: cb_ld_len, stride: cb_ld_stride, next: cb_ld_next};

    dma_rb_decode u_dec (
        .win  (bus_win),
        .addr (bus_addr),
        .be   (bus_be),
        .dec  (dec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_sel, ld_sel;
        assign wr_sel = bus_req && bus_we && dec.chan_hit && (dec.chan == CH_W'(i));
        assign ld_sel = cb_ld_valid && (cb_ld_chan == CH_W'(i));

        dma_rb_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .rsel    (dec.rsel),
            .wdata   (bus_wdata),
            .done    (eng_done[i]),
            .ld      (ld_sel),
            .cb_in   (cb_load),
            .cs_rd   (cs_rd[i]),
            .cba     (cba_rd[i]),
            .dbg     (dbg_rd[i]),
            .cb      (cb_rd[i]),
            .start   (eng_start[i]),
            .irq     (chan_irq[i]),
            .int_set (int_set[i]),
            .int_clr (int_clr[i])
        );
    end

    always_comb begin
        case (dec.rsel)
            RG_CS:     chan_word = cs_rd[dec.chan];
            RG_CBA:    chan_word = cba_rd[dec.chan];
            RG_INFO:   chan_word = cb_rd[dec.chan].info;
            RG_SRC:    chan_word = cb_rd[dec.chan].src;
            RG_DST:    chan_word = cb_rd[dec.chan].dst;
            RG_LEN:    chan_word = cb_rd[dec.chan].len;
            RG_STRIDE: chan_word = cb_rd[dec.chan].stride;
            RG_NEXT:   chan_word = cb_rd[dec.chan].next;
            RG_DBG:    chan_word = dbg_rd[dec.chan];
            default:   chan_word = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.rdata = '0;
        st_d.gstat = (st_q.gstat | int_set) & ~int_clr;
        if (bus_req) begin
            if (dec.bad) begin
                st_d.err = 1'b1;
            end else if (dec.gen_hit) begin
                if (bus_we) st_d.gen   = bus_wdata[NUM_CH-1:0];
                else        st_d.rdata = {{(DW-NUM_CH){1'b0}}, st_q.gen};
            end else if (dec.gstat_hit) begin
                if (!bus_we) st_d.rdata = {{(DW-NUM_CH){1'b0}}, st_q.gstat};
            end else if (!bus_we) begin
                st_d.rdata = chan_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gstat <= '0;
            st_q.gen   <= '1;
            st_q.rdata <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign bus_err     = st_q.err;
    assign chan_enable = st_q.gen;

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
    parameter int NCH = 16,
    parameter int W   = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_we,
    input logic           bus_err,
    input logic [W-1:0]   bus_rdata,
    input logic [NCH-1:0] eng_start,
    input logic [NCH-1:0] eng_done,
    input logic [NCH-1:0] chan_irq,
    input logic [NCH-1:0] gstat
);

    AST_SUMMARY_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        gstat == chan_irq); // R7

    AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start & $past(eng_start)) == '0); // R6

    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |-> $past(bus_req && bus_we)); // R6

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0)); // R9

    AST_ERR_AFTER_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req)); // R9

    for (genvar i = 0; i < NCH; i++) begin : g_irq
        AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_irq[i]) |-> $past(eng_done[i])); // R8
    end

endmodule

bind dma_regbank dma_regbank_chk #(
    .NCH (dma_rb_pkg::NUM_CH),
    .W   (dma_rb_pkg::DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .chan_irq  (chan_irq),
    .gstat     (st_q.gstat)
);

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_win = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        cb_ld_valid = 1'b0;
    logic [3:0]  cb_ld_chan = '0;
    logic [31:0] cb_ld_info = '0, cb_ld_src = '0, cb_ld_dst = '0;
    logic [31:0] cb_ld_len = '0, cb_ld_stride = '0, cb_ld_next = '0;
    logic [15:0] eng_done = '0;
    logic [15:0] eng_start, chan_enable, chan_irq;

    int total = 0;
    int bad = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    dma_regbank u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_win(bus_win), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cb_ld_valid(cb_ld_valid), .cb_ld_chan(cb_ld_chan), .cb_ld_info(cb_ld_info),
        .cb_ld_src(cb_ld_src), .cb_ld_dst(cb_ld_dst), .cb_ld_len(cb_ld_len),
        .cb_ld_stride(cb_ld_stride), .cb_ld_next(cb_ld_next),
        .eng_done(eng_done), .eng_start(eng_start),
        .chan_enable(chan_enable), .chan_irq(chan_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected response per accepted request
    always @(posedge clk) begin
        sb_item_t it;
        if (rst_n && bus_req) begin
            #2;
            if (sb_q.size() == 0) begin
                check(32'h1, 32'h0, "scoreboard underflow");
            end else begin
                it = sb_q.pop_front();
                check(bus_rdata, it.data, it.tag);
                check({31'b0, bus_err}, {31'b0, it.err}, it.tag);
            end
        end
    end

    task automatic acc(input bit win, input logic [11:0] a, input bit we, input logic [31:0] wd,
                       input logic [3:0] be, input logic [31:0] exp, input bit experr, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_req = 1'b1; bus_win = win; bus_addr = a; bus_we = we; bus_wdata = wd; bus_be = be;
        it.data = exp; it.err = experr; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic wr(input bit win, input logic [11:0] a, input logic [31:0] d, input string tag);
        acc(win, a, 1'b1, d, 4'hF, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input bit win, input logic [11:0] a, input logic [31:0] exp, input string tag);
        acc(win, a, 1'b0, 32'h0, 4'hF, exp, 1'b0, tag);
    endtask

    function automatic logic [11:0] ca(input int ch, input logic [7:0] off);
        return {4'(ch), off};
    endfunction

    task automatic pulse_done(input int ch);
        @(negedge clk);
        eng_done[ch] = 1'b1;
        @(negedge clk);
        eng_done = '0;
    endtask

    task automatic load_cb(input int ch, input logic [31:0] info, input logic [31:0] base);
        @(negedge clk);
        cb_ld_valid = 1'b1; cb_ld_chan = 4'(ch); cb_ld_info = info;
        cb_ld_src = base + 32'h1; cb_ld_dst = base + 32'h2; cb_ld_len = base + 32'h3;
        cb_ld_stride = base + 32'h4; cb_ld_next = base + 32'h5;
        @(negedge clk);
        cb_ld_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 12'hFF0, 32'h0000_FFFF, "R1 enable reset");
        rd(0, 12'hFE0, 32'h0, "R1 summary reset");
        rd(0, ca(0, 8'h00), 32'h10, "R1 cs reset");
        rd(0, ca(3, 8'h04), 32'h0, "R1 cba reset");
        rd(1, 12'h000, 32'h10, "R1 ch15 cs reset");
        check({16'h0, chan_irq}, 32'h0, "R1 irq reset");

        // R12 / R2 read-write registers and channel selection
        wr(0, ca(2, 8'h04), 32'hDEAD_BEE0, "R12 cba write");
        wr(0, ca(5, 8'h20), 32'hA5A5_0F0F, "R12 dbg write");
        wr(1, 12'h020, 32'h1234_5678, "R2 ch15 dbg write");
        rd(0, ca(2, 8'h04), 32'hDEAD_BEE0, "R12 cba readback");
        rd(0, ca(5, 8'h20), 32'hA5A5_0F0F, "R12 dbg readback");
        rd(0, ca(4, 8'h20), 32'h0, "R2 other channel untouched");
        rd(1, 12'h020, 32'h1234_5678, "R2 ch15 window dbg");
        rd(1, 12'h504, 32'h0, "R2 ch15 ignores upper bits");

        // R3 masked write, R11 idle bit
        wr(0, ca(4, 8'h00), 32'h7FFF_FFF0, "R3 masked write");
        rd(0, ca(4, 8'h00), 32'h30FF_0010, "R3 masked readback");
        check({16'h0, eng_start}, 32'h0, "R6 no start without active");

        // R6 start pulse
        wr(0, ca(1, 8'h00), 32'h1, "R6 set active");
        check({16'h0, eng_start}, 32'h0002, "R6 start pulse");
        @(negedge clk);
        check({16'h0, eng_start}, 32'h0, "R6 start one cycle");
        rd(0, ca(1, 8'h00), 32'h1, "R11 idle clear while active");
        wr(0, ca(1, 8'h00), 32'h1, "R6 rewrite active");
        check({16'h0, eng_start}, 32'h0, "R6 no second start");

        // R5 mirror registers
        load_cb(1, 32'h1, 32'h1000);
        rd(0, ca(1, 8'h08), 32'h1, "R5 info");
        rd(0, ca(1, 8'h0C), 32'h1001, "R5 src");
        rd(0, ca(1, 8'h10), 32'h1002, "R5 dst");
        rd(0, ca(1, 8'h14), 32'h1003, "R5 len");
        rd(0, ca(1, 8'h18), 32'h1004, "R5 stride");
        rd(0, ca(1, 8'h1C), 32'h1005, "R5 next");
        wr(0, ca(1, 8'h08), 32'hFFFF_FFFE, "R5 write info");
        wr(0, ca(1, 8'h10), 32'h0, "R5 write dst");
        rd(0, ca(1, 8'h08), 32'h1, "R5 info unchanged");
        rd(0, ca(1, 8'h10), 32'h1002, "R5 dst unchanged");

        // R8 completion with interrupt
        pulse_done(1);
        check({16'h0, chan_irq}, 32'h0002, "R8 irq raised");
        rd(0, ca(1, 8'h00), 32'h16, "R8 cs after done");
        rd(0, 12'hFE0, 32'h0002, "R8 summary set");
        wr(0, 12'hFE0, 32'hFFFF_FFFF, "R10 summary write");
        rd(0, 12'hFE0, 32'h0002, "R10 summary write ignored");

        // R7 write-one-to-clear
        wr(0, ca(1, 8'h00), 32'h4, "R7 clear int");
        check({16'h0, chan_irq}, 32'h0, "R7 irq cleared");
        rd(0, ca(1, 8'h00), 32'h12, "R7 cs after int clear");
        rd(0, 12'hFE0, 32'h0, "R7 summary cleared");
        wr(0, ca(1, 8'h00), 32'h2, "R7 clear end");
        rd(0, ca(1, 8'h00), 32'h10, "R7 end cleared");

        // R8 done ignored when idle; done without interrupt enable
        pulse_done(1);
        check({16'h0, chan_irq}, 32'h0, "R8 idle done no irq");
        rd(0, ca(1, 8'h00), 32'h10, "R8 idle done no change");
        wr(0, ca(6, 8'h00), 32'h1, "R6 start ch6");
        check({16'h0, eng_start}, 32'h0040, "R6 start ch6 pulse");
        pulse_done(6);
        check({16'h0, chan_irq}, 32'h0, "R8 no irq when disabled");
        rd(0, ca(6, 8'h00), 32'h12, "R8 end without int");

        // R4 reset bit
        wr(0, ca(1, 8'h00), 32'h1, "R4 restart");
        pulse_done(1);
        check({16'h0, chan_irq}, 32'h0002, "R4 irq before reset");
        wr(0, ca(1, 8'h00), 32'h80FF_0001, "R4 reset write");
        check({16'h0, chan_irq}, 32'h0, "R4 irq after reset");
        check({16'h0, eng_start}, 32'h0, "R4 no start on reset write");
        rd(0, ca(1, 8'h00), 32'h10, "R4 cs after reset");
        rd(0, 12'hFE0, 32'h0, "R4 summary after reset");

        // R9 invalid accesses
        acc(0, 12'hF04, 1'b0, 32'h0, 4'hF, 32'h0, 1'b1, "R9 undecoded read");
        acc(0, ca(0, 8'h24), 1'b1, 32'hFFFF_FFFF, 4'hF, 32'h0, 1'b1, "R9 undecoded write");
        acc(0, ca(2, 8'h06), 1'b0, 32'h0, 4'hF, 32'h0, 1'b1, "R9 misaligned read");
        acc(0, ca(2, 8'h04), 1'b1, 32'h0000_0001, 4'h3, 32'h0, 1'b1, "R9 partial write");
        rd(0, ca(2, 8'h04), 32'hDEAD_BEE0, "R9 partial write no effect");
        acc(0, ca(2, 8'h04), 1'b0, 32'h0, 4'h1, 32'h0, 1'b1, "R9 partial read");

        // R10 enable word
        wr(0, 12'hFF0, 32'hABCD_1234, "R10 enable write");
        rd(0, 12'hFF0, 32'h0000_1234, "R10 enable readback");
        check({16'h0, chan_enable}, 32'h1234, "R10 enable port");

        // R2 channel 15 through its own window
        wr(1, 12'h000, 32'h1, "R2 ch15 start");
        check({16'h0, eng_start}, 32'h8000, "R2 ch15 start pulse");
        load_cb(15, 32'h1, 32'h2000);
        rd(1, 12'h01C, 32'h2005, "R2 ch15 next mirror");
        pulse_done(15);
        check({16'h0, chan_irq}, 32'h8000, "R8 ch15 irq");
        rd(0, 12'hFE0, 32'h8000, "R8 ch15 summary");
        rd(0, ca(14, 8'h00), 32'h10, "R2 ch14 separate from ch15");

        repeat (3) @(negedge clk);
        check(sb_q.size(), 32'h0, "scoreboard drained");
        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule